// File: doc/BRIEF.md
# Master-Mode Audio Bit and Frame Clock Generator

When the audio port is bus master, this block produces the serial bit clock and the left/right frame clock for it. The bit clock comes from the input clock through a 4-bit ratio code. The frame clock comes from counting bit-clock periods, using an 11-bit length field. The frame length is set on its own and does not track the converter sample rate. Software therefore has to choose a bit-clock ratio fast enough for the sample rate it wants and a frame length that matches. A length too short to be usable is reported on a configuration error output.

The input clock runs at twice the system clock rate. Because of this, every ratio in the set, including the half-integer ones, is a whole number of input cycles. The block also gives two single-cycle strobes: one when a frame begins and one when the frame clock drops halfway through the frame. Both line up with a falling edge of the bit clock. Configuration must be written before the block is enabled. Changes made while it is running wait for the next frame boundary.

Top module: `afc_master_clkgen`

## Requirements
- R1: While reset is asserted, bit_clk, frame_clk, frame_start, chan_flip, clk_oe and cfg_err are all low.
- R2: One bit_clk period lasts T input cycles, where bit_ratio values 0 to 15 give T = 2, 3, 4, 6, 8, 11, 12, 16, 22, 24, 32, 44, 48, 64, 88, 96. The clock is high for floor(T/2) cycles and low for the rest.
- R3: A frame lasts frame_bits bit_clk periods. frame_clk is high for the first floor(frame_bits/2) periods and low for the remaining ones.
- R4: frame_clk changes only in the input cycle where bit_clk falls.
- R5: frame_start is a one-cycle pulse at the falling bit_clk edge that begins each frame, with frame_clk going high. chan_flip is a one-cycle pulse where frame_clk goes low. The two strobes are never high together.
- R6: When the latched frame_bits is below 8, cfg_err is high, frame_clk stays low, no frame_start is produced, and bit_clk keeps running. Writing a valid length while running takes effect at the next falling bit_clk edge.
- R7: When is_master or run_en is low, bit_clk, frame_clk, both strobes and clk_oe are low from the next cycle on. clk_oe goes high one cycle after both inputs are high.
- R8: A change to bit_ratio or frame_bits made while running leaves the current frame as it is. The new values apply from the next frame_start.
- R9: bit_clk rises in the first cycle after is_master and run_en are both sampled high. The first frame starts at the first bit_clk falling edge, floor(T/2) cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, twice the system clock rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| is_master | input | 1 | High when the port drives its own clocks |
| run_en | input | 1 | Starts clock generation |
| bit_ratio | input | 4 | Bit-clock ratio code |
| frame_bits | input | 11 | Frame length in bit-clock periods |
| bit_clk | output | 1 | Serial bit clock |
| frame_clk | output | 1 | Left/right frame clock |
| frame_start | output | 1 | Frame-begin strobe |
| chan_flip | output | 1 | Strobe on frame_clk falling |
| clk_oe | output | 1 | Enable for the clock output drivers |
| cfg_err | output | 1 | Latched frame length is below 8 |

## Verification
The properties assume that bit_ratio and frame_bits are stable for at least one cycle before run_en rises. That is the only window in which configuration is copied without waiting for a frame boundary. They also assume that run_en is low while reset is held. The stimulus follows both rules: every run starts by dropping run_en, writing the configuration, waiting three cycles and only then enabling. Live changes are made only in the mid-frame and short-length tests, where the boundary latching is the behaviour being checked.

// File: rtl/afc_pkg.sv
package afc_pkg;
    localparam int CODE_W = 4;
    localparam int TICK_W = 7;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [TICK_W-1:0] tick_t;

    // Input cycles per bit-clock period; the input runs at twice the system rate.
    function automatic tick_t ticks_per_bit(input code_t code);
        tick_t t;
        case (code)
            4'd0:    t = 7'd2;
            4'd1:    t = 7'd3;
            4'd2:    t = 7'd4;
            4'd3:    t = 7'd6;
            4'd4:    t = 7'd8;
            4'd5:    t = 7'd11;
            4'd6:    t = 7'd12;
            4'd7:    t = 7'd16;
            4'd8:    t = 7'd22;
            4'd9:    t = 7'd24;
            4'd10:   t = 7'd32;
            4'd11:   t = 7'd44;
            4'd12:   t = 7'd48;
            4'd13:   t = 7'd64;
            4'd14:   t = 7'd88;
            default: t = 7'd96;
        endcase
        return t;
    endfunction
endpackage

// File: rtl/afc_bclk_div.sv
module afc_bclk_div
    import afc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  active,
    input  logic  boundary,
    input  tick_t tick_cur,
    input  tick_t tick_nxt,
    output logic  bclk,
    output logic  fall
);
    typedef struct packed {
        tick_t ph;
        logic  bclk;
    } div_st_t;

    div_st_t s_q, s_d;
    tick_t   ph_inc;
    tick_t   half_cur;

    // Phase step and falling-edge detect kept apart from the next-state logic.
    always_comb begin
        half_cur = tick_cur >> 1;
        ph_inc   = (s_q.ph >= tick_cur - tick_t'(1)) ? '0 : s_q.ph + tick_t'(1);
        fall     = active && (ph_inc == half_cur);
    end

    always_comb begin
        s_d = s_q;
        if (!active) begin
            s_d.ph   = tick_nxt - tick_t'(1);
            s_d.bclk = 1'b0;
        end else if (boundary) begin
            s_d.ph   = tick_nxt >> 1;
            s_d.bclk = 1'b0;
        end else begin
            s_d.ph   = ph_inc;
            s_d.bclk = (ph_inc < half_cur);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: '0, bclk: 1'b0};
        else        s_q <= s_d;
    end

    assign bclk = s_q.bclk;
endmodule

// File: rtl/afc_frame_ctr.sv
module afc_frame_ctr #(
    parameter int LEN_W   = 11,
    parameter int MIN_LEN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             fall,
    input  logic [LEN_W-1:0] len_cur,
    input  logic [LEN_W-1:0] len_nxt,
    output logic             boundary,
    output logic             fclk,
    output logic             frame_start,
    output logic             chan_flip
);
    typedef logic [LEN_W-1:0] len_t;

    typedef struct packed {
        len_t bitn;
        logic fclk;
        logic fs;
        logic cf;
    } frm_st_t;

    frm_st_t s_q, s_d;
    logic    len_bad;
    logic    at_last;
    logic    nxt_ok;
    len_t    half;
    len_t    bit_inc;

    // Frame boundary: last bit of a valid frame, or every edge while the length is unusable.
    always_comb begin
        len_bad  = len_cur < len_t'(MIN_LEN);
        at_last  = s_q.bitn >= len_cur - len_t'(1);
        boundary = active && fall && (len_bad || at_last);
    end

    always_comb begin
        s_d     = s_q;
        s_d.fs  = 1'b0;
        s_d.cf  = 1'b0;
        half    = len_cur >> 1;
        bit_inc = s_q.bitn + len_t'(1);
        nxt_ok  = len_nxt >= len_t'(MIN_LEN);
        if (!active) begin
            s_d.bitn = '1;
            s_d.fclk = 1'b0;
        end else if (boundary) begin
            s_d.bitn = '0;
            s_d.fclk = nxt_ok;
            s_d.fs   = nxt_ok;
        end else if (fall) begin
            s_d.bitn = bit_inc;
            s_d.fclk = bit_inc < half;
            s_d.cf   = bit_inc == half;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{bitn: '1, fclk: 1'b0, fs: 1'b0, cf: 1'b0};
        else        s_q <= s_d;
    end

    assign fclk        = s_q.fclk;
    assign frame_start = s_q.fs;
    assign chan_flip   = s_q.cf;
endmodule

// File: rtl/afc_master_clkgen.sv
module afc_master_clkgen
    import afc_pkg::*;
#(
    parameter int LEN_W   = 11,
    parameter int MIN_LEN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_master,
    input  logic             run_en,
    input  logic [3:0]       bit_ratio,
    input  logic [LEN_W-1:0] frame_bits,
    output logic             bit_clk,
    output logic             frame_clk,
    output logic             frame_start,
    output logic             chan_flip,
    output logic             clk_oe,
    output logic             cfg_err
);
    typedef logic [LEN_W-1:0] len_t;

    typedef struct packed {
        tick_t tick;
        len_t  len;
        logic  oe;
        logic  err;
    } top_st_t;

    top_st_t s_q, s_d;
    logic    active;
    logic    boundary;
    logic    fall;
    tick_t   tick_in;

    assign active  = is_master && run_en;
    assign tick_in = ticks_per_bit(code_t'(bit_ratio));

    // Settings follow the inputs while idle and are re-taken only at a frame boundary.
    always_comb begin
        s_d = s_q;
        if (!active || boundary) begin
            s_d.tick = tick_in;
            s_d.len  = frame_bits;
        end
        s_d.oe  = active;
        s_d.err = s_d.len < len_t'(MIN_LEN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{tick: 7'd2, len: '0, oe: 1'b0, err: 1'b0};
        else        s_q <= s_d;
    end

    afc_bclk_div u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .boundary (boundary),
        .tick_cur (s_q.tick),
        .tick_nxt (s_d.tick),
        .bclk     (bit_clk),
        .fall     (fall)
    );

    afc_frame_ctr #(
        .LEN_W   (LEN_W),
        .MIN_LEN (MIN_LEN)
    ) u_frm (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (active),
        .fall        (fall),
        .len_cur     (s_q.len),
        .len_nxt     (s_d.len),
        .boundary    (boundary),
        .fclk        (frame_clk),
        .frame_start (frame_start),
        .chan_flip   (chan_flip)
    );

    assign clk_oe  = s_q.oe;
    assign cfg_err = s_q.err;
endmodule

// File: rtl/afc_master_clkgen_chk.sv
module afc_master_clkgen_chk (
    input logic clk,
    input logic rst_n,
    input logic is_master,
    input logic run_en,
    input logic bit_clk,
    input logic frame_clk,
    input logic frame_start,
    input logic chan_flip,
    input logic clk_oe,
    input logic cfg_err
);
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_master && run_en) |=> (!bit_clk && !frame_clk && !clk_oe && !frame_start && !chan_flip));

    a_r4_fclk_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_oe && (frame_clk != $past(frame_clk))) |-> $fell(bit_clk));

    a_r5_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (frame_clk && $fell(bit_clk)));

    a_r5_flip_edge: assert property (@(posedge clk) disable iff (!rst_n)
        chan_flip |-> $fell(frame_clk));

    a_r5_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_start, chan_flip}));

    a_r6_err_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!frame_clk && !frame_start));
endmodule

bind afc_master_clkgen afc_master_clkgen_chk u_chk (.*);

// File: tb/afc_master_clkgen_bench.sv
`timescale 1ns/1ps
module afc_master_clkgen_bench;
    typedef struct packed {
        logic [3:0]  code;
        logic [10:0] len;
        logic [6:0]  ticks;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{4'd0,  11'd8,  7'd2},
        '{4'd1,  11'd9,  7'd3},
        '{4'd2,  11'd16, 7'd4},
        '{4'd5,  11'd11, 7'd11},
        '{4'd7,  11'd12, 7'd16},
        '{4'd10, 11'd13, 7'd32},
        '{4'd15, 11'd20, 7'd96},
        '{4'd12, 11'd64, 7'd48}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        is_master;
    logic        run_en;
    logic [3:0]  bit_ratio;
    logic [10:0] frame_bits;
    logic        bit_clk, frame_clk, frame_start, chan_flip, clk_oe, cfg_err;

    int tests = 0;
    int fails = 0;
    int r4_bad = 0;

    always #2.5 clk = ~clk;

    afc_master_clkgen u_afc_master_clkgen (
        .clk(clk), .rst_n(rst_n), .is_master(is_master), .run_en(run_en),
        .bit_ratio(bit_ratio), .frame_bits(frame_bits),
        .bit_clk(bit_clk), .frame_clk(frame_clk), .frame_start(frame_start),
        .chan_flip(chan_flip), .clk_oe(clk_oe), .cfg_err(cfg_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic restart(input logic [3:0] code, input logic [10:0] len);
        @(negedge clk);
        run_en     = 1'b0;
        bit_ratio  = code;
        frame_bits = len;
        repeat (3) @(negedge clk);
        run_en = 1'b1;
    endtask

    task automatic wait_fs();
        @(negedge clk);
        while (!frame_start) @(negedge clk);
    endtask

    // Runs from one frame_start sample to the next; optionally rewrites settings mid-frame.
    task automatic span(input int chg_at, input logic [3:0] nc, input logic [10:0] nl,
                        output int falls, output int hi, output int flips, output int cyc);
        logic pb, pf;
        falls = 1; hi = frame_clk ? 1 : 0; flips = 0; cyc = 0;
        pb = bit_clk; pf = frame_clk;
        forever begin
            @(negedge clk);
            cyc++;
            if (frame_start) break;
            if (pb && !bit_clk) begin
                falls++;
                if (frame_clk) hi++;
                if (falls == chg_at) begin
                    bit_ratio  = nc;
                    frame_bits = nl;
                end
            end else if (frame_clk != pf) begin
                r4_bad++;
            end
            if (chan_flip) flips++;
            pb = bit_clk; pf = frame_clk;
        end
    endtask

    task automatic bclk_phase(output int hi, output int lo);
        hi = 0; lo = 0;
        @(negedge clk);
        while (bit_clk) @(negedge clk);
        while (!bit_clk) @(negedge clk);
        while (bit_clk) begin hi++; @(negedge clk); end
        while (!bit_clk) begin lo++; @(negedge clk); end
    endtask

    initial begin
        #750000;
        fails++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int falls, hi, flips, cyc, lo, cnt, seen;
        rst_n = 1'b0; is_master = 1'b1; run_en = 1'b0;
        bit_ratio = 4'd0; frame_bits = 11'd8;
        repeat (3) @(negedge clk);
        // R1: everything low under reset
        check("R1 reset bit_clk", int'(bit_clk), 0);
        check("R1 reset frame_clk", int'(frame_clk), 0);
        check("R1 reset strobes", int'(frame_start | chan_flip), 0);
        check("R1 reset clk_oe", int'(clk_oe), 0);
        check("R1 reset cfg_err", int'(cfg_err), 0);
        rst_n = 1'b1;

        // R2 R3 R5: table of ratio codes and frame lengths
        for (int i = 0; i < NVEC; i++) begin
            restart(VECS[i].code, VECS[i].len);
            wait_fs();
            span(-1, 4'd0, 11'd0, falls, hi, flips, cyc);
            check($sformatf("R3 vec%0d frame periods", i), falls, int'(VECS[i].len));
            check($sformatf("R3 vec%0d high periods", i), hi, int'(VECS[i].len) / 2);
            check($sformatf("R5 vec%0d flips", i), flips, 1);
            check($sformatf("R2 vec%0d frame cycles", i), cyc, int'(VECS[i].len) * int'(VECS[i].ticks));
            bclk_phase(hi, lo);
            check($sformatf("R2 vec%0d bclk high", i), hi, int'(VECS[i].ticks) / 2);
            check($sformatf("R2 vec%0d bclk low", i), lo, int'(VECS[i].ticks) - int'(VECS[i].ticks) / 2);
        end
        check("R4 frame_clk moved off falling edge", r4_bad, 0);

        // R9: start-up timing, T=6, length 8
        restart(4'd3, 11'd8);
        @(negedge clk);
        check("R9 first bclk high", int'(bit_clk), 1);
        check("R7 clk_oe after enable", int'(clk_oe), 1);
        check("R9 frame_clk low before start", int'(frame_clk), 0);
        repeat (2) @(negedge clk);
        check("R9 bclk still high", int'(bit_clk), 1);
        @(negedge clk);
        check("R9 first fall", int'(bit_clk), 0);
        check("R9 first frame_start", int'(frame_start), 1);
        check("R9 frame_clk high at start", int'(frame_clk), 1);

        // R8: change mid-frame, T=4 L=16 then T=8 L=10
        restart(4'd2, 11'd16);
        wait_fs();
        span(5, 4'd4, 11'd10, falls, hi, flips, cyc);
        check("R8 current frame periods kept", falls, 16);
        check("R8 current frame cycles kept", cyc, 64);
        span(-1, 4'd0, 11'd0, falls, hi, flips, cyc);
        check("R8 new frame periods", falls, 10);
        check("R8 new frame cycles", cyc, 80);

        // R6: unusable length 5 with T=2
        restart(4'd0, 11'd5);
        hi = 0; seen = 0; cnt = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (frame_clk) hi++;
            if (frame_start) seen++;
            if (bit_clk) cnt++;
        end
        check("R6 frame_clk held low", hi, 0);
        check("R6 no frame_start", seen, 0);
        check("R6 cfg_err raised", int'(cfg_err), 1);
        check("R6 bit_clk running", int'(cnt > 0), 1);
        frame_bits = 11'd8;
        seen = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (frame_start) seen = 1;
        end
        check("R6 recovery frame_start", seen, 1);
        check("R6 cfg_err cleared", int'(cfg_err), 0);

        // R7: slave mode and disabled master stay quiet
        @(negedge clk);
        is_master = 1'b0;
        @(negedge clk);
        cnt = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (bit_clk | frame_clk | clk_oe | frame_start | chan_flip) cnt++;
        end
        check("R7 slave outputs low", cnt, 0);
        is_master = 1'b1; run_en = 1'b0;
        @(negedge clk);
        cnt = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (bit_clk | frame_clk | clk_oe | frame_start | chan_flip) cnt++;
        end
        check("R7 disabled outputs low", cnt, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule